// File: doc/BRIEF.md
# Two-Address Register-Memory Processor Core

This block is a compact word-oriented processor. It has eight 16-bit general registers and shares one synchronous memory port between instruction fetch and data access. Two of the registers have a fixed role. R7 is the program counter, so an ordinary move into R7 acts as a jump. R6 is the stack pointer and starts at the top of memory. Registers are read and written only as whole 16-bit words.

Each instruction names a destination register and a source. The destination is also the left operand. The source is either a register or a memory word whose address sits in a second instruction word. The instructions are register move, load, store, add, subtract, multiply, unsigned divide and halt. Arithmetic results update the zero and negative flags. A divide by zero yields all-ones and raises an error flag.

The controller is a state machine with these states:
- S_FETCH presents R7 on the memory port.
- S_DECODE latches the word, increments R7, and goes to S_EXT_REQ when an address word follows. It goes to S_EXEC for register forms and to S_HALT for halt or an unknown opcode.
- S_EXT_REQ presents R7.
- S_EXT_LAT latches the address and increments R7. It then goes to S_STORE for a store and to S_OPER_REQ otherwise.
- S_OPER_REQ presents the operand address and goes to S_EXEC.
- S_EXEC writes the destination and returns to S_FETCH.
- S_STORE writes memory and returns to S_FETCH.
- S_HALT is never left until reset.

Top module: `gpr2_core`

## Requirements
- R1: Instruction word layout: bits [15:12] opcode, [11:9] destination register, [8:6] source register, [5] memory-source flag, [4:0] ignored. Opcodes are 0 move, 1 add, 2 sub, 3 mul, 4 div, 5 store and 15 halt. Any other opcode halts. Move and arithmetic with bit 5 set, and every store, are followed by one word holding a 16-bit memory address.
- R2: After reset R7 is 0, R6 is 2**MEM_AW-1, R0 to R5 are 0, all three flags are 0, the memory write enable is low, and the first fetch address is 0.
- R3: Move copies a register into a register, or with bit 5 set loads the word at the address into the destination register. Store (opcode 5) writes the source register to the word at the address.
- R4: Add, sub and mul compute destination op source modulo 2**16, with the destination as the left operand, from a register source or a memory source.
- R5: Div gives the unsigned quotient destination / source. A zero divisor writes 0xFFFF and sets flag_dz. A div by a nonzero value clears flag_dz. Nothing else changes flag_dz.
- R6: flag_z (result is zero) and flag_n (result bit 15) are updated by add, sub, mul and div only. Move and store leave them unchanged.
- R7: R7 is incremented after each instruction word is read. An instruction that reads R7 sees the address following its last word. A move into R7 redirects the next fetch to the written value.
- R8: A store raises mem_we for exactly one cycle, with the address and data of that instruction.
- R9: After halt or an unknown opcode, halted goes high and stays high, and no memory write happens until reset.
- R10: Cycle cost is 3 cycles for a register-source instruction, 6 for a load or a memory-source arithmetic, 5 for a store, and 2 from the halt fetch until halted is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| flag_z | output | 1 | Last arithmetic result was zero |
| flag_n | output | 1 | Last arithmetic result had bit 15 set |
| flag_dz | output | 1 | Last divide had a zero divisor |

## Verification
A wrong program counter shows up on mem_addr at the very next fetch. Instructions then run from the wrong words, which typically changes the stored results and the cycle count to halt within one instruction. A corrupted register, instruction latch or address latch shows up as a wrong value or address on the next store of that register. A stale or misplaced flag update is visible on the flag pins one cycle after the execute state. Random programs therefore load operands, compute, store and halt, and the bench compares the stored word, the flags and the cycle count.

// File: rtl/gpr2_pkg.sv
package gpr2_pkg;

    localparam int DW   = 16;
    localparam int NREG = 8;
    localparam int RAW  = $clog2(NREG);

    localparam logic [3:0] OP_MOV  = 4'd0;
    localparam logic [3:0] OP_ADD  = 4'd1;
    localparam logic [3:0] OP_SUB  = 4'd2;
    localparam logic [3:0] OP_MUL  = 4'd3;
    localparam logic [3:0] OP_DIV  = 4'd4;
    localparam logic [3:0] OP_STO  = 4'd5;
    localparam logic [3:0] OP_HALT = 4'd15;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXT_REQ,
        S_EXT_LAT,
        S_OPER_REQ,
        S_EXEC,
        S_STORE,
        S_HALT
    } state_t;

endpackage

// File: rtl/gpr2_alu.sv
module gpr2_alu #(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         div_zero
);
    import gpr2_pkg::*;

    logic [2*W-1:0] prod;

    assign prod     = a * b;
    assign div_zero = (b == '0);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[W-1:0];
            OP_DIV:  y = div_zero ? '1 : a / b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/gpr2_regfile.sv
module gpr2_regfile #(
    parameter int          W        = 16,
    parameter int          N        = 8,
    parameter logic [15:0] SP_RESET = 16'hFFFF,
    localparam int         AW       = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          pc_inc,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  pc
);
    logic [N-1:0][W-1:0] q;

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [W-1:0] RST = (g == N - 2) ? W'(SP_RESET) : '0;
        logic [W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= RST;
            else if (we && waddr == AW'(g))
                r <= wdata;
            else if (g == N - 1 && pc_inc)
                r <= r + 1'b1;
        end
        assign q[g] = r;
    end

    assign rdata_a = q[raddr_a];
    assign rdata_b = q[raddr_b];
    assign pc      = q[N-1];
endmodule

// File: rtl/gpr2_core.sv
module gpr2_core #(
    parameter int MEM_AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        halted,
    output logic        flag_z,
    output logic        flag_n,
    output logic        flag_dz
);
    import gpr2_pkg::*;

    localparam logic [15:0] SP_RESET = 16'((32'd1 << MEM_AW) - 32'd1);

    state_t state, state_nx;

    logic [3:0]     ir_op;
    logic [RAW-1:0] ir_dst;
    logic [RAW-1:0] ir_src;
    logic           ir_mem;
    logic [DW-1:0]  ea;

    logic [3:0] f_op;
    logic       f_mem;
    logic       f_known;
    logic       f_ext;

    logic           rf_we;
    logic           rf_pc_inc;
    logic [DW-1:0]  rf_wdata;
    logic [DW-1:0]  rf_a;
    logic [DW-1:0]  rf_b;
    logic [DW-1:0]  pc;
    logic [DW-1:0]  src_val;
    logic [DW-1:0]  alu_y;
    logic           alu_dz;

    // decode of the word arriving in S_DECODE
    assign f_op    = mem_rdata[15:12];
    assign f_mem   = mem_rdata[5];
    assign f_known = (f_op <= OP_STO);
    assign f_ext   = (f_op == OP_STO) || (f_mem && f_op <= OP_DIV);

    assign src_val = ir_mem ? mem_rdata : rf_b;

    gpr2_regfile #(
        .W       (DW),
        .N       (NREG),
        .SP_RESET(SP_RESET)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (ir_dst),
        .wdata  (rf_wdata),
        .pc_inc (rf_pc_inc),
        .raddr_a(ir_dst),
        .raddr_b(ir_src),
        .rdata_a(rf_a),
        .rdata_b(rf_b),
        .pc     (pc)
    );

    gpr2_alu #(.W(DW)) u_alu (
        .op      (ir_op),
        .a       (rf_a),
        .b       (src_val),
        .y       (alu_y),
        .div_zero(alu_dz)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH:    state_nx = S_DECODE;
            S_DECODE: begin
                if (!f_known)   state_nx = S_HALT;
                else if (f_ext) state_nx = S_EXT_REQ;
                else            state_nx = S_EXEC;
            end
            S_EXT_REQ:  state_nx = S_EXT_LAT;
            S_EXT_LAT:  state_nx = (ir_op == OP_STO) ? S_STORE : S_OPER_REQ;
            S_OPER_REQ: state_nx = S_EXEC;
            S_EXEC:     state_nx = S_FETCH;
            S_STORE:    state_nx = S_FETCH;
            S_HALT:     state_nx = S_HALT;
        endcase
    end

    // instruction, address and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_op   <= OP_MOV;
            ir_dst  <= '0;
            ir_src  <= '0;
            ir_mem  <= 1'b0;
            ea      <= '0;
            flag_z  <= 1'b0;
            flag_n  <= 1'b0;
            flag_dz <= 1'b0;
        end else begin
            if (state == S_DECODE) begin
                ir_op  <= f_op;
                ir_dst <= mem_rdata[11:9];
                ir_src <= mem_rdata[8:6];
                ir_mem <= f_mem && (f_op <= OP_DIV);
            end
            if (state == S_EXT_LAT)
                ea <= mem_rdata;
            if (state == S_EXEC && ir_op != OP_MOV) begin
                flag_z <= (alu_y == '0);
                flag_n <= alu_y[DW-1];
                if (ir_op == OP_DIV)
                    flag_dz <= alu_dz;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = rf_b;
        rf_we     = 1'b0;
        rf_pc_inc = 1'b0;
        rf_wdata  = (ir_op == OP_MOV) ? src_val : alu_y;
        halted    = 1'b0;
        unique case (state)
            S_FETCH:    mem_addr  = pc;
            S_DECODE:   rf_pc_inc = 1'b1;
            S_EXT_REQ:  mem_addr  = pc;
            S_EXT_LAT:  rf_pc_inc = 1'b1;
            S_OPER_REQ: mem_addr  = ea;
            S_EXEC:     rf_we     = 1'b1;
            S_STORE: begin
                mem_addr = ea;
                mem_we   = 1'b1;
            end
            S_HALT:     halted    = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpr2_core_chk.sv
module gpr2_core_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              halted,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_dz,
    input gpr2_pkg::state_t  state,
    input logic [3:0]        ir_op
);
    import gpr2_pkg::*;

    // R8: one write cycle per store
    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9: halt is sticky and silent
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we));

    // R6: zero and negative flags move only after an arithmetic execute
    a_r6_flags_arith_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_z, flag_n}) |-> ($past(state) == S_EXEC && $past(ir_op) != OP_MOV));

    // R5: divide error flag moves only after a divide execute
    a_r5_dz_div_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_dz) |-> ($past(state) == S_EXEC && $past(ir_op) == OP_DIV));

    // R10: a store cycle always follows the address-latch cycle
    a_r10_store_after_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STORE) |-> ($past(state) == S_EXT_LAT));
endmodule

bind gpr2_core gpr2_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_we (mem_we),
    .halted (halted),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_dz(flag_dz),
    .state  (state),
    .ir_op  (ir_op)
);

// File: tb/gpr2_core_bench.sv
module gpr2_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;
    logic        flag_z;
    logic        flag_n;
    logic        flag_dz;

    logic        ld_clr = 1'b0;
    logic        ld_en  = 1'b0;
    logic [7:0]  ld_a   = '0;
    logic [15:0] ld_d   = '0;
    logic [15:0] mem [0:255];

    int checks = 0;
    int fails  = 0;
    int pp     = 0;
    int cycles_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr2_core #(.MEM_AW(8)) u_gpr2_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .halted   (halted),
        .flag_z   (flag_z),
        .flag_n   (flag_n),
        .flag_dz  (flag_dz)
    );

    always_ff @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0;
        end else if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cycles_total++;
        if (cycles_total > 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] ins(logic [3:0] op, int d, int s, logic m);
        return {op, 3'(d), 3'(s), m, 5'b0};
    endfunction

    function automatic logic [15:0] exp_alu(logic [3:0] op, logic [15:0] a, logic [15:0] b);
        logic [31:0] p;
        p = a * b;
        case (op)
            4'd1:    return a + b;
            4'd2:    return a - b;
            4'd3:    return p[15:0];
            default: return (b == 16'h0) ? 16'hFFFF : a / b;
        endcase
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(int a, logic [15:0] d);
        ld_a  = a[7:0];
        ld_d  = d;
        ld_en = 1'b1;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic emit(logic [15:0] w);
        put(pp, w);
        pp++;
    endtask

    task automatic begin_prog();
        rst_n  = 1'b0;
        ld_clr = 1'b1;
        @(posedge clk);
        #1 ld_clr = 1'b0;
        pp = 0;
    endtask

    task automatic run(output int cyc);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) begin
            fails++;
            $display("FAIL R9 program did not halt: actual running expected halted");
        end
    endtask

    initial begin
        int cyc;
        void'($urandom(32'd24680));
        @(posedge clk);
        #1;

        // R2: reset state at the ports
        begin_prog();
        @(negedge clk);
        check("R2", "fetch address", mem_addr, 16'h0);
        check("R2", "write enable", {15'b0, mem_we}, 16'h0);
        check("R2", "halted/flags", {12'b0, halted, flag_z, flag_n, flag_dz}, 16'h0);
        @(posedge clk);
        #1;

        // R2, R7, R10: register reset values, PC readback, store timing
        begin_prog();
        emit(ins(4'd5, 0, 6, 1'b0)); emit(16'd200);
        emit(ins(4'd5, 0, 3, 1'b0)); emit(16'd201);
        emit(ins(4'd5, 0, 7, 1'b0)); emit(16'd202);
        emit(ins(4'd15, 0, 0, 1'b0));
        run(cyc);
        check("R2", "R6 reset", mem[200], 16'd255);
        check("R2", "R3 reset", mem[201], 16'd0);
        check("R7", "R7 read by store", mem[202], 16'd6);
        check("R10", "store cycles", 16'(cyc), 16'd17);

        // R1, R3, R4, R5, R6, R10: random arithmetic
        for (int i = 0; i < 40; i++) begin
            logic [3:0]  op;
            logic [15:0] a, b, y;
            logic        um;
            op = 4'(1 + (i % 4));
            a  = 16'($urandom);
            b  = 16'($urandom);
            if (op == 4'd4 && (i % 8) == 3) b = 16'h0;
            if (op == 4'd4 && (i % 8) == 7) b = 16'($urandom % 16);
            um = 1'($urandom);
            begin_prog();
            emit(ins(4'd0, 1, 0, 1'b1)); emit(16'd100);
            emit(ins(4'd0, 2, 0, 1'b1)); emit(16'd101);
            if (um) begin
                emit(ins(op, 1, 0, 1'b1)); emit(16'd101);
            end else begin
                emit(ins(op, 1, 2, 1'b0));
            end
            emit(ins(4'd5, 0, 1, 1'b0)); emit(16'd102);
            emit(ins(4'd15, 0, 0, 1'b0));
            put(100, a);
            put(101, b);
            run(cyc);
            y = exp_alu(op, a, b);
            check(op == 4'd4 ? "R5" : "R4", "result", mem[102], y);
            check("R6", "z/n", {14'b0, flag_z, flag_n}, {14'b0, y == 16'h0, y[15]});
            check("R5", "dz", {15'b0, flag_dz}, {15'b0, op == 4'd4 && b == 16'h0});
            check("R10", "cycles", 16'(cyc), um ? 16'd25 : 16'd22);
        end

        // R4: sub order and dst==src
        begin_prog();
        emit(ins(4'd0, 3, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd2, 3, 0, 1'b1)); emit(16'd101);
        emit(ins(4'd5, 0, 3, 1'b0)); emit(16'd102);
        emit(ins(4'd1, 3, 3, 1'b0));
        emit(ins(4'd5, 0, 3, 1'b0)); emit(16'd103);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'd5); put(101, 16'd7);
        run(cyc);
        check("R4", "5-7", mem[102], 16'hFFFE);
        check("R4", "r+r", mem[103], 16'hFFFC);
        check("R6", "n after add", {15'b0, flag_n}, 16'd1);

        // R1, R4: spare bits ignored, mul keeps low half
        begin_prog();
        emit(ins(4'd0, 4, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd0, 5, 0, 1'b1)); emit(16'd101);
        emit(ins(4'd3, 4, 5, 1'b0) | 16'h001F & ~16'h0020);
        emit(ins(4'd5, 0, 4, 1'b0)); emit(16'd102);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'h1234); put(101, 16'h0100);
        run(cyc);
        check("R1", "mul with spare bits", mem[102], 16'h3400);

        // R6, R3: moves leave flags
        begin_prog();
        emit(ins(4'd0, 1, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd2, 1, 1, 1'b0));
        emit(ins(4'd0, 2, 0, 1'b1)); emit(16'd101);
        emit(ins(4'd0, 3, 2, 1'b0));
        emit(ins(4'd5, 0, 3, 1'b0)); emit(16'd102);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'd5); put(101, 16'h8000);
        run(cyc);
        check("R3", "reg-reg move", mem[102], 16'h8000);
        check("R6", "flags after moves", {14'b0, flag_z, flag_n}, 16'b10);

        // R5: div by zero, then nonzero div clears the flag
        begin_prog();
        emit(ins(4'd0, 1, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd4, 1, 0, 1'b0));
        emit(ins(4'd5, 0, 1, 1'b0)); emit(16'd102);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'd9);
        run(cyc);
        check("R5", "div0 value", mem[102], 16'hFFFF);
        check("R5", "div0 flag", {15'b0, flag_dz}, 16'd1);
        begin_prog();
        emit(ins(4'd0, 1, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd4, 1, 0, 1'b0));
        emit(ins(4'd0, 2, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd4, 2, 0, 1'b1)); emit(16'd101);
        emit(ins(4'd5, 0, 2, 1'b0)); emit(16'd103);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'd40000); put(101, 16'd3);
        run(cyc);
        check("R5", "unsigned quotient", mem[103], 16'd13333);
        check("R5", "flag cleared", {15'b0, flag_dz}, 16'd0);

        // R7: move into R7 jumps
        begin_prog();
        emit(ins(4'd0, 2, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd0, 7, 2, 1'b0));
        emit(ins(4'd5, 0, 2, 1'b0)); emit(16'd103);
        emit(ins(4'd15, 0, 0, 1'b0));
        pp = 20;
        emit(ins(4'd5, 0, 2, 1'b0)); emit(16'd104);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'd20);
        run(cyc);
        check("R7", "skipped store", mem[103], 16'd0);
        check("R7", "jump target ran", mem[104], 16'd20);

        // R9, R1: unknown opcode halts, halt is sticky
        begin_prog();
        emit(ins(4'd0, 1, 0, 1'b1)); emit(16'd100);
        emit(ins(4'd9, 1, 1, 1'b0));
        emit(ins(4'd5, 0, 1, 1'b0)); emit(16'd102);
        emit(ins(4'd15, 0, 0, 1'b0));
        put(100, 16'hBEEF);
        run(cyc);
        check("R10", "halt cycles", 16'(cyc), 16'd8);
        repeat (20) @(negedge clk);
        check("R9", "still halted", {15'b0, halted}, 16'd1);
        check("R9", "no store after halt", mem[102], 16'd0);
        check("R8", "no write while halted", {15'b0, mem_we}, 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule